// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Four SRAM

A cycle-accurate, synthesizable model of a static memory with a dedicated read data path and a dedicated write data path, both fed from one shared address bus. Every rising clock edge is a slot. After reset the slots alternate: read slot, write slot, read slot, and so on. A read address can be accepted in a read slot and a write address in a write slot. Each address names a location of four words. The words move as a burst of two beat pairs. Each pair uses a rise lane and a fall lane, so the burst finishes in two clock periods without true double-rate I/O.

Writes are staged in a buffer and reach the array only after all four beats and their byte enables have been captured. A read that is formed while a finished write is still staged merges the staged bytes over the array contents. Every read therefore returns the newest data accepted before its own address was captured.

Top module: `qdr_burst_sram`

## Requirements
- R1: While rst_ni is low, rd_valid_o, rd_rise_o and rd_fall_o are all zero.
- R2: The first rising edge after reset release is a read slot, and slots alternate from then on. rd_sel_ni (active low) is sampled only in read slots and wr_sel_ni (active low) only in write slots. A select asserted in the other slot has no effect.
- R3: When a read is accepted at edge E, the cycle after edge E+1 carries beats 0 and 1 on rd_rise_o and rd_fall_o, and the cycle after edge E+2 carries beats 2 and 3. rd_valid_o is high in exactly those two cycles.
- R4: For a write accepted at write-slot edge E, beats 0 and 1 are taken from wd_rise_i and wd_fall_i at edge E, and beats 2 and 3 from the same inputs at edge E+1. Beat n of a location is word n of that location.
- R5: bw_rise_ni and bw_fall_ni are active-low byte enables for the beat on the matching lane, sampled with that beat. Bit y covers data bits [y*BYTE_W +: BYTE_W]. A byte whose enable is high keeps its previous value.
- R6: A read accepted at the read-slot edge that completes a write returns that write's merged data, even though the array is updated one edge later.
- R7: A read select in a read slot while a read burst has not yet presented its second pair is ignored. The next read can be accepted four edges after the previous one.
- R8: A write accepted while a read burst is being presented does not disturb that burst, and it is stored correctly.
- R9: A write whose address is captured after a read's address capture does not change that read's data, even when the addresses are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Shared location address, read in read slots, written in write slots |
| rd_sel_ni | input | 1 | Active-low read request |
| wr_sel_ni | input | 1 | Active-low write request |
| wd_rise_i | input | WORD_W | Write beat 0 (first edge) or beat 2 (second edge) |
| wd_fall_i | input | WORD_W | Write beat 1 (first edge) or beat 3 (second edge) |
| bw_rise_ni | input | WORD_W/BYTE_W | Active-low byte enables for the rise-lane beat |
| bw_fall_ni | input | WORD_W/BYTE_W | Active-low byte enables for the fall-lane beat |
| rd_rise_o | output | WORD_W | Read beat 0, then beat 2 |
| rd_fall_o | output | WORD_W | Read beat 1, then beat 3 |
| rd_valid_o | output | 1 | High during the two cycles that carry a read burst |

## Verification
The bench builds the block with ADDR_W=4, WORD_W=18 and BYTE_W=9. That gives two byte lanes per word and only sixteen locations. With so few locations, random traffic often reads a location in the slot right after a write to it, which exercises the forwarding path and the read-then-write ordering far more than a large address space would. The two byte lanes let partial byte enables leave one half of a word untouched where it can be seen.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned BEAT_W    = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_FIRST  = 2'd1,
    RD_SECOND = 2'd2
  } rd_state_e;
endpackage

// File: rtl/qdr_wbuf.sv
module qdr_wbuf
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 18,
  parameter int unsigned NB     = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cap_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [WORD_W-1:0]                  rise_i,
  input  logic [WORD_W-1:0]                  fall_i,
  input  logic [NB-1:0]                      be_rise_i,
  input  logic [NB-1:0]                      be_fall_i,
  output logic                               full_o,
  output logic [ADDR_W-1:0]                  addr_o,
  output logic [BURST_LEN-1:0][WORD_W-1:0]   data_o,
  output logic [BURST_LEN-1:0][NB-1:0]       be_o
);
  logic half_q, full_q;
  logic [ADDR_W-1:0]                addr_q;
  logic [BURST_LEN-1:0][WORD_W-1:0] data_q;
  logic [BURST_LEN-1:0][NB-1:0]     be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      full_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else begin
      half_q <= cap_i;
      full_q <= half_q;
      if (cap_i) begin
        addr_q    <= addr_i;
        data_q[0] <= rise_i;
        data_q[1] <= fall_i;
        be_q[0]   <= be_rise_i;
        be_q[1]   <= be_fall_i;
      end
      if (half_q) begin
        data_q[2] <= rise_i;
        data_q[3] <= fall_i;
        be_q[2]   <= be_rise_i;
        be_q[3]   <= be_fall_i;
      end
    end
  end

  assign full_o = full_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
  assign be_o   = be_q;

  // R4
  wr_half_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !half_q);
endmodule

// File: rtl/qdr_mem.sv
module qdr_mem
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 18,
  parameter int unsigned BYTE_W = 9,
  parameter int unsigned NB     = 2
) (
  input  logic                             clk_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                waddr_i,
  input  logic [BURST_LEN-1:0][WORD_W-1:0] wdata_i,
  input  logic [BURST_LEN-1:0][NB-1:0]     wbe_i,
  input  logic [ADDR_W-1:0]                raddr_i,
  output logic [BURST_LEN-1:0][WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = (1 << ADDR_W) * BURST_LEN;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int b = 0; b < BURST_LEN; b++) begin
        for (int y = 0; y < NB; y++) begin
          if (wbe_i[b][y])
            mem_q[{waddr_i, BEAT_W'(b)}][y*BYTE_W +: BYTE_W] <= wdata_i[b][y*BYTE_W +: BYTE_W];
        end
      end
    end
  end

  for (genvar gb = 0; gb < BURST_LEN; gb++) begin : g_rd
    assign rdata_o[gb] = mem_q[{raddr_i, BEAT_W'(gb)}];
  end
endmodule

// File: rtl/qdr_rd.sv
module qdr_rd
  import qdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 18,
  parameter int unsigned BYTE_W = 9,
  parameter int unsigned NB     = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             req_i,
  input  logic [ADDR_W-1:0]                addr_i,
  output logic [ADDR_W-1:0]                raddr_o,
  input  logic [BURST_LEN-1:0][WORD_W-1:0] mem_data_i,
  input  logic                             fwd_hit_i,
  input  logic [BURST_LEN-1:0][WORD_W-1:0] fwd_data_i,
  input  logic [BURST_LEN-1:0][NB-1:0]     fwd_be_i,
  output logic [WORD_W-1:0]                rise_o,
  output logic [WORD_W-1:0]                fall_o,
  output logic                             valid_o
);
  rd_state_e                        state_q;
  logic [ADDR_W-1:0]                raddr_q;
  logic [1:0][WORD_W-1:0]           hold_q;
  logic [BURST_LEN-1:0][WORD_W-1:0] merged;

  // staged write bytes win over array bytes
  always_comb begin
    for (int b = 0; b < BURST_LEN; b++) begin
      for (int y = 0; y < NB; y++) begin
        merged[b][y*BYTE_W +: BYTE_W] = (fwd_hit_i && fwd_be_i[b][y])
          ? fwd_data_i[b][y*BYTE_W +: BYTE_W] : mem_data_i[b][y*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      raddr_q <= '0;
      hold_q  <= '0;
      rise_o  <= '0;
      fall_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      unique case (state_q)
        RD_IDLE: begin
          valid_o <= 1'b0;
          if (req_i) begin
            raddr_q <= addr_i;
            state_q <= RD_FIRST;
          end
        end
        RD_FIRST: begin
          rise_o    <= merged[0];
          fall_o    <= merged[1];
          hold_q[0] <= merged[2];
          hold_q[1] <= merged[3];
          valid_o   <= 1'b1;
          state_q   <= RD_SECOND;
        end
        RD_SECOND: begin
          rise_o  <= hold_q[0];
          fall_o  <= hold_q[1];
          valid_o <= 1'b1;
          state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign raddr_o = raddr_q;

  // R3
  rd_pair_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |=> valid_o);
  // R3
  rd_burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |=> !valid_o);
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter  int unsigned ADDR_W = 6,
  parameter  int unsigned WORD_W = 18,
  parameter  int unsigned BYTE_W = 9,
  localparam int unsigned NB     = WORD_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [WORD_W-1:0] wd_rise_i,
  input  logic [WORD_W-1:0] wd_fall_i,
  input  logic [NB-1:0]     bw_rise_ni,
  input  logic [NB-1:0]     bw_fall_ni,
  output logic [WORD_W-1:0] rd_rise_o,
  output logic [WORD_W-1:0] rd_fall_o,
  output logic              rd_valid_o
);
  logic slot_wr_q;
  logic wr_cap, rd_req, wb_full, fwd_hit;
  logic [ADDR_W-1:0]                wb_addr, rd_addr;
  logic [BURST_LEN-1:0][WORD_W-1:0] wb_data, mem_data;
  logic [BURST_LEN-1:0][NB-1:0]     wb_be;

  // slot 0 = read, 1 = write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_wr_q <= 1'b0;
    else         slot_wr_q <= !slot_wr_q;
  end

  assign wr_cap  = slot_wr_q && !wr_sel_ni;
  assign rd_req  = !slot_wr_q && !rd_sel_ni;
  assign fwd_hit = wb_full && (wb_addr == rd_addr);

  qdr_wbuf #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NB(NB)) u_wbuf (
    .clk_i, .rst_ni,
    .cap_i     (wr_cap),
    .addr_i,
    .rise_i    (wd_rise_i),
    .fall_i    (wd_fall_i),
    .be_rise_i (~bw_rise_ni),
    .be_fall_i (~bw_fall_ni),
    .full_o    (wb_full),
    .addr_o    (wb_addr),
    .data_o    (wb_data),
    .be_o      (wb_be)
  );

  qdr_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .NB(NB)) u_mem (
    .clk_i,
    .we_i    (wb_full),
    .waddr_i (wb_addr),
    .wdata_i (wb_data),
    .wbe_i   (wb_be),
    .raddr_i (rd_addr),
    .rdata_o (mem_data)
  );

  qdr_rd #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W), .NB(NB)) u_rd (
    .clk_i, .rst_ni,
    .req_i      (rd_req),
    .addr_i,
    .raddr_o    (rd_addr),
    .mem_data_i (mem_data),
    .fwd_hit_i  (fwd_hit),
    .fwd_data_i (wb_data),
    .fwd_be_i   (wb_be),
    .rise_o     (rd_rise_o),
    .fall_o     (rd_fall_o),
    .valid_o    (rd_valid_o)
  );

  // R2
  rd_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> !slot_wr_q);
  // R4
  commit_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_full |-> slot_wr_q);
endmodule

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 4;
  localparam int WW   = 18;
  localparam int BW   = 9;
  localparam int NB   = WW / BW;
  localparam int NLOC = 1 << AW;

  logic clk, rst_n;
  logic [AW-1:0] addr;
  logic rd_sel_n, wr_sel_n;
  logic [WW-1:0] wd_rise, wd_fall;
  logic [NB-1:0] bw_rise_n, bw_fall_n;
  logic [WW-1:0] rd_rise, rd_fall;
  logic rd_valid;

  qdr_burst_sram #(.ADDR_W(AW), .WORD_W(WW), .BYTE_W(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .rd_sel_ni(rd_sel_n), .wr_sel_ni(wr_sel_n),
    .wd_rise_i(wd_rise), .wd_fall_i(wd_fall),
    .bw_rise_ni(bw_rise_n), .bw_fall_ni(bw_fall_n),
    .rd_rise_o(rd_rise), .rd_fall_o(rd_fall), .rd_valid_o(rd_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  logic [WW-1:0] ref_mem [NLOC*4];
  int k = 0, busy_end = -1, sched = -10;
  bit pend = 0;
  logic [AW-1:0] pend_addr;
  logic [WW-1:0] pend_d0, pend_d1;
  logic [NB-1:0] pend_m0, pend_m1;
  logic [WW-1:0] snap [4];
  bit exp_v;
  logic [WW-1:0] exp_r, exp_f;
  bit nx_pend = 0;
  logic [WW-1:0] nx_r, nx_f;
  logic [NB-1:0] nx_bw_r, nx_bw_f;

  function automatic logic [WW-1:0] merge(logic [WW-1:0] old_w, logic [WW-1:0] new_w,
                                         logic [NB-1:0] bw_n);
    logic [WW-1:0] r = old_w;
    for (int y = 0; y < NB; y++)
      if (!bw_n[y]) r[y*BW +: BW] = new_w[y*BW +: BW];
    return r;
  endfunction

  task automatic chk(string what, logic [WW-1:0] act, logic [WW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (edge %0d)", tag, what, act, exp, k);
    end
  endtask

  // reference update at a clock edge, from the pin values present there
  task automatic model_edge();
    if (pend) begin
      ref_mem[{pend_addr, 2'd0}] = merge(ref_mem[{pend_addr, 2'd0}], pend_d0, pend_m0);
      ref_mem[{pend_addr, 2'd1}] = merge(ref_mem[{pend_addr, 2'd1}], pend_d1, pend_m1);
      ref_mem[{pend_addr, 2'd2}] = merge(ref_mem[{pend_addr, 2'd2}], wd_rise, bw_rise_n);
      ref_mem[{pend_addr, 2'd3}] = merge(ref_mem[{pend_addr, 2'd3}], wd_fall, bw_fall_n);
      pend = 0;
    end
    if ((k % 2) == 1 && !wr_sel_n) begin
      pend = 1; pend_addr = addr;
      pend_d0 = wd_rise; pend_d1 = wd_fall;
      pend_m0 = bw_rise_n; pend_m1 = bw_fall_n;
    end
    if ((k % 2) == 0 && !rd_sel_n && k > busy_end) begin
      for (int b = 0; b < 4; b++) snap[b] = ref_mem[{addr, 2'(b)}];
      sched = k + 1;
      busy_end = k + 2;
    end
    exp_v = 0;
    if (k == sched) begin
      exp_v = 1; exp_r = snap[0]; exp_f = snap[1];
    end else if (k == sched + 1) begin
      exp_v = 1; exp_r = snap[2]; exp_f = snap[3];
    end
    k++;
  endtask

  task automatic cycle(bit want_rd, bit want_wr, logic [AW-1:0] a, bit full_mask);
    addr = a;
    if ((k % 2) == 0) begin
      rd_sel_n = !want_rd;
      wr_sel_n = 1'($urandom % 2);
      if (nx_pend) begin
        wd_rise = nx_r; wd_fall = nx_f; bw_rise_n = nx_bw_r; bw_fall_n = nx_bw_f;
        nx_pend = 0;
      end else begin
        wd_rise = WW'($urandom); wd_fall = WW'($urandom);
        bw_rise_n = NB'($urandom); bw_fall_n = NB'($urandom);
      end
    end else begin
      wr_sel_n = !want_wr;
      rd_sel_n = 1'($urandom % 2);
      wd_rise = WW'($urandom); wd_fall = WW'($urandom);
      bw_rise_n = full_mask ? '0 : NB'($urandom);
      bw_fall_n = full_mask ? '0 : NB'($urandom);
      if (want_wr) begin
        nx_pend = 1;
        nx_r = WW'($urandom); nx_f = WW'($urandom);
        nx_bw_r = full_mask ? '0 : NB'($urandom);
        nx_bw_f = full_mask ? '0 : NB'($urandom);
      end
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("valid", WW'(rd_valid), WW'(exp_v));
    if (exp_v) begin
      chk("rise", rd_rise, exp_r);
      chk("fall", rd_fall, exp_f);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 0, '0, 0);
  endtask

  task automatic wr_op(logic [AW-1:0] a, bit full_mask);
    if ((k % 2) == 0) cycle(0, 0, '0, 0);
    cycle(0, 1, a, full_mask);
  endtask

  task automatic rd_op(logic [AW-1:0] a);
    if ((k % 2) == 1) cycle(0, 0, '0, 0);
    cycle(1, 0, a, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    rst_n = 0; addr = '0; rd_sel_n = 1; wr_sel_n = 1;
    wd_rise = '0; wd_fall = '0; bw_rise_n = '1; bw_fall_n = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    chk("reset valid", WW'(rd_valid), '0);
    chk("reset rise", rd_rise, '0);
    chk("reset fall", rd_fall, '0);
    rst_n = 1;

    tag = "R4";   // fill every location with full enables
    for (int i = 0; i < NLOC; i++) wr_op(AW'(i), 1);
    idle(2);
    tag = "R3";   // read back each location, latency and beat order
    for (int i = 0; i < NLOC; i++) begin rd_op(AW'(i)); idle(3); end

    tag = "R5";   // partial byte enables
    for (int i = 0; i < 4; i++) begin wr_op(AW'(3 + i), 0); idle(2); rd_op(AW'(3 + i)); idle(4); end

    tag = "R6";   // read right after the completing edge of a write
    for (int i = 0; i < 4; i++) begin wr_op(AW'(5 + i), i[0]); rd_op(AW'(5 + i)); idle(4); end

    tag = "R9";   // write captured right after a read to the same location
    for (int i = 0; i < 4; i++) begin rd_op(AW'(7 + i)); wr_op(AW'(7 + i), 1); idle(4); rd_op(AW'(7 + i)); idle(4); end

    tag = "R7";   // second read during a burst is dropped
    for (int i = 0; i < 3; i++) begin rd_op(AW'(2)); rd_op(AW'(9)); idle(5); end

    tag = "R8";   // writes during a read burst
    rd_op(AW'(4)); wr_op(AW'(11), 1); wr_op(AW'(12), 0); idle(1);
    rd_op(AW'(11)); idle(3); rd_op(AW'(12)); idle(4);

    tag = "R2";   // random mix; off-slot selects are random junk
    for (int i = 0; i < 4000; i++)
      cycle(1'($urandom % 2), 1'($urandom % 2), AW'($urandom), ($urandom % 4) == 0);
    idle(4);
    finish_run();
  end
endmodule